// File: doc/BRIEF.md
# Floppy Head-Step Command Sequencer

This block carries out the head-positioning commands of a floppy disk controller. A host hands it one 8-bit command byte with a single-cycle valid strobe. The block decodes the byte as one of five positioning operations: return to track zero, seek to a target, repeat the last step, step inward, or step outward. It then drives a stepper motor interface through a step pulse and a direction level. The block keeps its own track register and holds a busy flag until the last step interval has fully run out.

The spacing between step pulses comes from the two lowest bits of the command byte. A strap input picks one of two controller variants, and the two variants decode the same two-bit code to different millisecond intervals. Time is counted in millisecond ticks. The number of clock cycles per tick is a parameter, so a bench can shrink the delays while keeping their ratios. The prescaler restarts on every accepted command, which keeps each pulse edge on a whole number of ticks from the acceptance edge.

The controller is one state machine with four states. IDLE waits for a legal command. SETUP holds the new direction for one tick. PULSE keeps the step output high. SETTLE waits out the rest of the interval. The transitions are:
- accept: IDLE to SETUP.
- launch: SETUP to PULSE, when a step is needed at the end of the setup tick.
- skip: SETUP to IDLE, when no step is needed.
- release: PULSE to SETTLE, after the pulse-width ticks.
- repeat: SETTLE to PULSE, when the interval has ended and another step is needed.
- finish: SETTLE to IDLE, when the interval has ended and no step is needed.

Top module: `step_seq`

## Requirements
- R1: The upper nibble of the command byte selects the operation: 0000 restore, 0001 seek, 001x step, 010x step-in, 011x step-out. Bits 3 and 2 are ignored. Any nibble with bit 7 set is ignored: busy stays low, no pulse is issued and the track register keeps its value.
- R2: With `variant_b` low, rate code bits[1:0] give step intervals of 00 = 6, 01 = 12, 10 = 20 and 11 = 30 ticks, measured from one step rising edge to the next.
- R3: With `variant_b` high, the codes give 00 = 6, 01 = 12, 10 = 2 and 11 = 3 ticks. The strap and the rate code are sampled only at the accepting clock edge.
- R4: `busy` rises on the edge that accepts the command. It falls exactly one interval after the last step rising edge. When no step is issued, it falls one tick after acceptance. After reset, `busy`, `step_out`, `dir_out`, `track` and `restore_fail` are all 0.
- R5: A command presented while busy is ignored. It has no effect on the pulse count, the intervals, the direction or the final track.
- R6: The direction output takes its new value at acceptance. The first step rises exactly one tick later. Each step pulse is high for PULSE_TICKS ticks, and PULSE_TICKS must be less than 2.
- R7: Seek latches `seek_target` at acceptance. It sets the direction toward the target (`dir_out` 1 means higher track numbers) and issues one pulse per interval, changing the track register by one per pulse, until the track equals the target. If the track already equals the target, no pulse is issued and the direction is unchanged.
- R8: Step-in issues exactly one pulse with `dir_out` = 1 and adds 1 to the track. Step-out issues exactly one pulse with `dir_out` = 0 and subtracts 1.
- R9: Step issues exactly one pulse in the last direction used by any command, and moves the track accordingly.
- R10: Restore drives `dir_out` = 0 and tests `at_track0` before every pulse. It pulses until that input is seen, then clears the track register to 0. If the input is high at the end of the setup tick, no pulse is issued.
- R11: If restore has issued RESTORE_LIMIT (255) pulses and `at_track0` is still low, `restore_fail` rises as busy falls. The flag stays high until the next command is accepted.
- R12: Every interval in clock cycles equals its tick count times CLK_PER_TICK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe, one cycle |
| cmd_byte | input | 8 | Command: operation in [7:4], rate code in [1:0] |
| seek_target | input | 8 | Seek destination track, sampled at acceptance |
| at_track0 | input | 1 | Head is at the outermost track |
| variant_b | input | 1 | Strap selecting the second interval table |
| step_out | output | 1 | Step pulse to the drive |
| dir_out | output | 1 | Step direction, 1 = toward higher tracks |
| busy | output | 1 | Command in progress |
| track | output | 8 | Current track register |
| restore_fail | output | 1 | Restore gave up without finding track zero |

## Verification
The bench measures every step rising edge in clock cycles against the interval tables. A decoder that swapped the two variants, or treated codes 10 and 11 alike, would produce wrong spacing on the affected codes. A bench that flips the strap and writes a second command while busy catches any design that samples the rate late, or that accepts a command mid-operation. Such a design would shift the pulse timing or add a pulse. Other directed cases each catch a distinct fault:
- A seek to the current track: a design that pulses anyway fails this case.
- A step after a step-out: a design that forgets the last direction fails this case.
- Restore with the head already at zero.
- Restore with the track-zero input never asserted, which shows whether the design gives up after exactly 255 pulses or runs on.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    localparam int RATE_W = 5;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RESTORE,
        OP_SEEK,
        OP_STEP,
        OP_STEP_IN,
        OP_STEP_OUT
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_SETTLE
    } state_e;

endpackage

// File: rtl/step_tick_gen.sv
module step_tick_gen #(
    parameter int CLK_PER_TICK = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_TICK - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick = !restart && (cnt_q == LAST);

endmodule

// File: rtl/step_rate_sel.sv
module step_rate_sel
    import step_seq_pkg::*;
(
    input  logic              variant_b,
    input  logic [1:0]        code,
    output logic [RATE_W-1:0] ticks
);
    always_comb begin
        unique case (code)
            2'b00:   ticks = RATE_W'(6);
            2'b01:   ticks = RATE_W'(12);
            2'b10:   ticks = variant_b ? RATE_W'(2) : RATE_W'(20);
            default: ticks = variant_b ? RATE_W'(3) : RATE_W'(30);
        endcase
    end
endmodule

// File: rtl/step_cmd_decode.sv
module step_cmd_decode
    import step_seq_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output op_e        op
);
    always_comb begin
        unique casez (cmd_byte[7:4])
            4'b0000: op = OP_RESTORE;
            4'b0001: op = OP_SEEK;
            4'b001?: op = OP_STEP;
            4'b010?: op = OP_STEP_IN;
            4'b011?: op = OP_STEP_OUT;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/step_seq.sv
module step_seq
    import step_seq_pkg::*;
#(
    parameter int CLK_PER_TICK  = 8000,
    parameter int PULSE_TICKS   = 1,
    parameter int RESTORE_LIMIT = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] seek_target,
    input  logic       at_track0,
    input  logic       variant_b,
    output logic       step_out,
    output logic       dir_out,
    output logic       busy,
    output logic [7:0] track,
    output logic       restore_fail
);
    localparam int NS_W = $clog2(RESTORE_LIMIT + 1);
    localparam logic [NS_W-1:0]   NS_LIMIT   = NS_W'(RESTORE_LIMIT);
    localparam logic [RATE_W-1:0] PULSE_LAST = RATE_W'(PULSE_TICKS - 1);

    state_e            state_q, state_d;
    op_e               dec_op, op_q;
    logic              tick, accept, need_step, decide, pulse_end, enter_pulse;
    logic              restore_ok, restore_bad;
    logic [RATE_W-1:0] rate_ticks, interval_q, elapsed_q;
    logic [7:0]        track_q, target_q;
    logic              dir_q, fail_q;
    logic [NS_W-1:0]   nsteps_q;

    step_cmd_decode u_decode (
        .cmd_byte (cmd_byte),
        .op       (dec_op)
    );

    step_rate_sel u_rate (
        .variant_b (variant_b),
        .code      (cmd_byte[1:0]),
        .ticks     (rate_ticks)
    );

    assign accept = cmd_valid && (state_q == ST_IDLE) && (dec_op != OP_NONE);

    step_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    // whether one more pulse is due at a decision point
    always_comb begin
        unique case (op_q)
            OP_SEEK:     need_step = (track_q != target_q);
            OP_RESTORE:  need_step = !at_track0 && (nsteps_q != NS_LIMIT);
            OP_STEP,
            OP_STEP_IN,
            OP_STEP_OUT: need_step = (nsteps_q == '0);
            default:     need_step = 1'b0;
        endcase
    end

    assign decide = tick && ((state_q == ST_SETUP) ||
                             ((state_q == ST_SETTLE) &&
                              (elapsed_q == interval_q - RATE_W'(1))));
    assign pulse_end   = tick && (state_q == ST_PULSE) && (elapsed_q == PULSE_LAST);
    assign enter_pulse = decide && need_step;
    assign restore_ok  = decide && (op_q == OP_RESTORE) && at_track0;
    assign restore_bad = decide && (op_q == OP_RESTORE) && !at_track0 &&
                         (nsteps_q == NS_LIMIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_SETUP;
            ST_SETUP,
            ST_SETTLE: if (decide)    state_d = need_step ? ST_PULSE : ST_IDLE;
            ST_PULSE:  if (pulse_end) state_d = ST_SETTLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command context and track datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_NONE;
            interval_q <= RATE_W'(6);
            elapsed_q  <= '0;
            target_q   <= '0;
            track_q    <= '0;
            dir_q      <= 1'b0;
            fail_q     <= 1'b0;
            nsteps_q   <= '0;
        end else begin
            if (accept) begin
                op_q       <= dec_op;
                interval_q <= rate_ticks;
                target_q   <= seek_target;
                nsteps_q   <= '0;
                fail_q     <= 1'b0;
                unique case (dec_op)
                    OP_RESTORE,
                    OP_STEP_OUT: dir_q <= 1'b0;
                    OP_STEP_IN:  dir_q <= 1'b1;
                    OP_SEEK: begin
                        if (seek_target > track_q)      dir_q <= 1'b1;
                        else if (seek_target < track_q) dir_q <= 1'b0;
                    end
                    default: dir_q <= dir_q;
                endcase
            end
            if (enter_pulse) begin
                elapsed_q <= '0;
                nsteps_q  <= nsteps_q + NS_W'(1);
                track_q   <= dir_q ? track_q + 8'd1 : track_q - 8'd1;
            end else if (tick && (state_q == ST_PULSE || state_q == ST_SETTLE)) begin
                elapsed_q <= elapsed_q + RATE_W'(1);
            end
            if (restore_ok)  track_q <= 8'd0;
            if (restore_bad) fail_q  <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        step_out     = (state_q == ST_PULSE);
        busy         = (state_q != ST_IDLE);
        dir_out      = dir_q;
        track        = track_q;
        restore_fail = fail_q;
    end

endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
    parameter int CLK_PER_TICK = 8000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       step_out,
    input logic       dir_out,
    input logic       busy,
    input logic [7:0] track,
    input logic       restore_fail
);
    logic        step_prev_q, seen_q;
    logic [31:0] gap_q;
    logic        step_rise;

    assign step_rise = step_out && !step_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_prev_q <= 1'b0;
            seen_q      <= 1'b0;
            gap_q       <= '0;
        end else begin
            step_prev_q <= step_out;
            if (step_rise) begin
                gap_q  <= 32'd1;
                seen_q <= 1'b1;
            end else begin
                if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 32'd1;
                if (!busy) seen_q <= 1'b0;
            end
        end
    end

    assert_busy_from_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    assert_illegal_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_byte[7]) |=> !busy);

    assert_step_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> busy);

    assert_dir_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_out) |-> $stable(dir_out));

    assert_track_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_out) |-> (track == 8'($past(track) + 8'd1) ||
                             track == 8'($past(track) - 8'd1)));

    assert_min_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && seen_q) |-> (gap_q >= 32'(2 * CLK_PER_TICK)));

    assert_fail_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_fail) |-> $fell(busy));

endmodule

bind step_seq step_seq_chk #(.CLK_PER_TICK(CLK_PER_TICK)) u_step_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_byte     (cmd_byte),
    .step_out     (step_out),
    .dir_out      (dir_out),
    .busy         (busy),
    .track        (track),
    .restore_fail (restore_fail)
);

// File: tb/test_step_seq.sv
`timescale 1ns/1ps
module test_step_seq;
    localparam int N  = 4;
    localparam int PT = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [7:0] seek_target = 8'h00;
    logic       variant_b = 1'b0;
    logic       at_track0;
    logic       step_out, dir_out, busy, restore_fail;
    logic [7:0] track;

    int  checks = 0, fails = 0, cyc = 0;
    int  head_pos = 0;
    bit  t0_ok = 1'b1;
    int  rise_t [0:299];
    bit  rise_d [0:299];
    int  nrise = 0, fall_t = -1, brise_t = -1, sfall_t = -1;
    bit  step_prev = 1'b0, busy_prev = 1'b0;
    int  exp_trk = 0;
    bit  exp_dir = 1'b0;

    assign at_track0 = t0_ok && (head_pos == 0);

    always #2 clk = ~clk;

    step_seq #(.CLK_PER_TICK(N), .PULSE_TICKS(PT)) i_step_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .seek_target(seek_target), .at_track0(at_track0), .variant_b(variant_b),
        .step_out(step_out), .dir_out(dir_out), .busy(busy), .track(track),
        .restore_fail(restore_fail)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (step_out && !step_prev) begin
                if (nrise < 300) begin
                    rise_t[nrise] = cyc;
                    rise_d[nrise] = dir_out;
                end
                nrise++;
                head_pos += dir_out ? 1 : -1;
            end
            if (!step_out && step_prev && sfall_t < 0) sfall_t = cyc;
            if (busy && !busy_prev) brise_t = cyc;
            if (!busy && busy_prev) fall_t = cyc;
        end
        step_prev = step_out;
        busy_prev = busy;
        if (cyc == 190000) begin
            checks++; fails++;
            $display("FAIL watchdog R4: run hung, actual cycle %0d expected below %0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_ticks(input bit vb, input logic [1:0] c);
        case (c)
            2'd0:    return 6;
            2'd1:    return 12;
            2'd2:    return vb ? 2 : 20;
            default: return vb ? 3 : 30;
        endcase
    endfunction

    task automatic run_cmd(input logic [7:0] cmd, input bit vb, input logic [7:0] tgt,
                           input bit inject);
        int a, ival, npul, etrk, bad, bdir;
        bit edir, efail;
        string rq;
        ival  = exp_ticks(vb, cmd[1:0]) * N;
        efail = 1'b0;
        edir  = exp_dir;
        case (cmd[7:4])
            4'h0: begin
                rq = "R10";
                npul = (!t0_ok || head_pos > 255) ? 255 : head_pos;
                edir = 1'b0;
                if (!t0_ok || head_pos > 255) begin
                    efail = 1'b1; rq = "R11";
                    etrk = (exp_trk - 255) & 255;
                end else etrk = 0;
            end
            4'h1: begin
                rq = "R7";
                npul = (tgt > exp_trk) ? (tgt - exp_trk) : (exp_trk - tgt);
                if (tgt > exp_trk) edir = 1'b1;
                else if (tgt < exp_trk) edir = 1'b0;
                etrk = tgt;
            end
            4'h2, 4'h3: begin
                rq = "R9"; npul = 1;
                etrk = (exp_trk + (exp_dir ? 1 : -1)) & 255;
            end
            4'h4, 4'h5: begin rq = "R8"; npul = 1; edir = 1'b1; etrk = (exp_trk + 1) & 255; end
            default:    begin rq = "R8"; npul = 1; edir = 1'b0; etrk = (exp_trk - 1) & 255; end
        endcase
        @(negedge clk);
        nrise = 0; fall_t = -1; brise_t = -1; sfall_t = -1;
        a = cyc + 1;
        cmd_valid = 1'b1; cmd_byte = cmd; variant_b = vb; seek_target = tgt;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_byte = 8'h00;
        if (inject) begin
            repeat (8) @(negedge clk);
            variant_b = !vb; cmd_valid = 1'b1; cmd_byte = 8'h4B; seek_target = tgt + 8'd5;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_byte = 8'h00;
        end
        while (busy) @(negedge clk);
        #1;
        check(brise_t == a, "R4 busy rise edge", brise_t, a);
        check(nrise == npul, {rq, " pulse count"}, nrise, npul);
        if (npul > 0 && nrise == npul) begin
            check(rise_t[0] == a + N, "R6 first step one tick after accept", rise_t[0], a + N);
            check(sfall_t - rise_t[0] == PT * N, "R6 step width", sfall_t - rise_t[0], PT * N);
            bad = 0; bdir = 0;
            for (int i = 1; i < npul && i < 300; i++)
                if (rise_t[i] - rise_t[i-1] != ival) bad++;
            for (int i = 0; i < npul && i < 300; i++)
                if (rise_d[i] != edir) bdir++;
            check(bad == 0, vb ? "R3 R12 step spacing" : "R2 R12 step spacing", bad, 0);
            check(bdir == 0, {rq, " direction at steps"}, bdir, 0);
            check(fall_t == rise_t[(npul < 300 ? npul : 300) - 1] + ival, "R4 busy fall after last interval",
                  fall_t, rise_t[(npul < 300 ? npul : 300) - 1] + ival);
        end else if (npul == 0) begin
            check(fall_t == a + N, "R4 busy fall without step", fall_t, a + N);
        end
        check(int'(track) == etrk, {rq, " final track"}, track, etrk);
        check(restore_fail == efail, "R11 fail flag", restore_fail, efail);
        exp_trk = etrk;
        exp_dir = edir;
    endtask

    task automatic illegal_cmd(input logic [7:0] cmd);
        @(negedge clk);
        nrise = 0; brise_t = -1;
        cmd_valid = 1'b1; cmd_byte = cmd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_byte = 8'h00;
        repeat (3 * N) @(negedge clk);
        #1;
        check(brise_t == -1 && !busy, "R1 illegal leaves busy low", busy, 0);
        check(nrise == 0 && int'(track) == exp_trk, "R1 illegal no step", track, exp_trk);
    endtask

    initial begin
        void'($urandom(32'h1581_5EED));
        repeat (5) @(negedge clk);
        check(!busy && !step_out && !dir_out && track == 8'd0 && !restore_fail,
              "R4 reset state", {busy, step_out, dir_out, restore_fail}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_cmd(8'h08, 1'b0, 8'd0, 1'b0);            // R10 already at zero
        run_cmd(8'h18, 1'b0, 8'd20, 1'b0);           // R7 seek in, 6 ticks
        for (int c = 0; c < 4; c++) begin
            run_cmd(8'h18 | 8'(c), 1'b0, 8'(24 + c), 1'b0);  // R2 each code
            run_cmd(8'h18 | 8'(c), 1'b1, 8'(20 + c), 1'b0);  // R3 each code
        end
        run_cmd(8'h1A, 1'b1, exp_trk[7:0], 1'b0);    // R7 seek to same track
        run_cmd(8'h4A, 1'b1, 8'd0, 1'b0);            // R8 step-in
        run_cmd(8'h2B, 1'b1, 8'd0, 1'b0);            // R9 repeats inward
        run_cmd(8'h69, 1'b0, 8'd0, 1'b0);            // R8 step-out
        run_cmd(8'h3A, 1'b1, 8'd0, 1'b0);            // R9 repeats outward
        illegal_cmd(8'h88);                          // R1
        illegal_cmd(8'hF0);
        illegal_cmd(8'hCB);
        run_cmd(8'h19, 1'b0, 8'd30, 1'b1);           // R5 R3 write while busy, strap flip
        run_cmd(8'h0B, 1'b0, 8'd0, 1'b1);            // R10 restore from track 30
        t0_ok = 1'b0; head_pos = 400;
        run_cmd(8'h0A, 1'b1, 8'd0, 1'b0);            // R11 gives up after 255
        t0_ok = 1'b1; head_pos = 3; exp_trk = int'(track);
        run_cmd(8'h0A, 1'b1, 8'd0, 1'b0);            // R11 flag cleared, R10 restore
        run_cmd(8'h18, 1'b1, 8'd30, 1'b0);

        for (int k = 0; k < 40; k++) begin
            int sel, t;
            logic [7:0] cb;
            bit vb;
            sel = $urandom % 5;
            vb  = 1'($urandom);
            cb  = {4'h0, 2'($urandom), 2'($urandom)};
            if (exp_trk < 2 && (sel == 3 || sel == 4)) sel = 2;
            if (sel == 0 && exp_trk >= 16) sel = 1;
            t = exp_trk + int'($urandom % 15) - 7;
            if (t < 0) t = 0;
            case (sel)
                0: cb[7:4] = 4'h0;
                1: cb[7:4] = 4'h1;
                2: cb[7:4] = 4'h4 | 4'($urandom % 2);
                3: cb[7:4] = 4'h6 | 4'($urandom % 2);
                default: cb[7:4] = exp_dir ? 4'h2 : 4'h6;
            endcase
            run_cmd(cb, vb, 8'(t), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule